// File: doc/BRIEF.md
# 8-bit Timer / Event Counter with Prescaler

This block is an 8-bit up-counter that can run in three ways: as a timer driven by a prescaled system tick, as an event counter that counts edges of an external input, or as a pulse-width meter. In pulse-width mode it counts prescaled ticks only while the external input sits at its active level. When the pulse ends, it stops itself by clearing its own run bit. Software must re-arm it before every measurement.

Software sees two write targets: a preload byte and a control word. It can also read the live count and the control word at any time. When the count passes its maximum, it wraps to the preload value and raises a single-cycle interrupt request. The external input first goes through a two-flop synchroniser. An edge detector then works on the synchronised copy, so a change on the pin affects the counter three clock edges later.

Control word layout (`ctrl`, write via `wr_sel`=1):
- bits [2:0]: prescale select. The division ratio is 2 to the power of the field, 1 to 128.
- bit 3: polarity.
- bit 4: run.
- bits [6:5]: mode. 00 is timer, 01 is event counter, 10 is pulse width, 11 is timer.
- bit 7: reads 0.

Top module: `evt_timer8`

## Requirements
- R1: After reset `count` is 0, `ctrl` is 0 and `irq` is 0.
- R2: A preload write (`wr_sel`=0) while run (ctrl bit 4) is 0 also loads `count` with the written value. While run is 1, a preload write leaves `count` untouched and only changes the value used at the next wrap.
- R3: In timer mode (ctrl[6:5]=00) with run=1, `count` advances by one on every 2^S-th high `tick`, where S=ctrl[2:0]. The prescaler restarts from zero whenever run is 0.
- R4: With run=0, or in timer mode with `tick` low, `count` holds its value.
- R5: A counting step taken at `count`=8'hFF loads the preload value, and `irq` is high for exactly the one cycle after that edge.
- R6: The external input is synchronised by two flops. An edge applied between clock edges is counted at the third following rising clock edge and not before.
- R7: In event mode (ctrl[6:5]=01) with run=1, each rising edge of `ext_in` adds one when polarity (ctrl bit 3) is 0, and each falling edge adds one when polarity is 1. Edges of the other direction are ignored, and `tick` is not needed.
- R8: In pulse-width mode (ctrl[6:5]=10), `count` advances on the prescaled tick only while `ext_in` is high (polarity 0) or low (polarity 1). The prescaler holds while the input is inactive.
- R9: In pulse-width mode, the end of the active level clears run (ctrl bit 4) in hardware. Further pulses are not counted until software sets run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | System tick enable feeding the prescaler |
| ext_in | input | 1 | Asynchronous external input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 preload, 1 control |
| wr_data | input | 8 | Write data |
| count | output | 8 | Live counter value |
| ctrl | output | 8 | Control word readback, including the hardware-cleared run bit |
| irq | output | 1 | Single-cycle overflow interrupt request |

## Verification
The bench targets the following corner cases:
- **Wrap from 8'hFF.** A wrong design reloads zero instead of the preload, or holds `irq` for more than one cycle.
- **Preload write during counting.** A wrong design would jump the live count.
- **Exact synchroniser latency.** An off-by-one here shifts every event count by one edge.
- **Edge-direction filtering.** Counting both edges doubles the result.
- **Pulse-width auto-stop.** A design that forgets to clear run keeps adding counts from a second pulse.
- **Prescaler hold outside the active level.** A design that lets the prescaler run here miscounts fractional periods.

Random timer runs over all eight prescale settings and random preloads compare the final count and the number of interrupts against a closed-form model.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_TIMER     = 2'b00,
    MD_EVENT     = 2'b01,
    MD_PULSE     = 2'b10,
    MD_TIMER_ALT = 2'b11
  } tmr_mode_e;

  localparam int PSEL_W   = 3;
  localparam int POL_BIT  = 3;
  localparam int RUN_BIT  = 4;
  localparam int MODE_LSB = 5;
  localparam int CTRL_W   = 7;
endpackage

// File: rtl/tmr_in_sync.sv
`timescale 1ns/1ps
module tmr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int STAGES = 7,
  parameter int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [STAGES-1:0] cnt_q;

  // true when the low 'sel' bits of the divider are all ones
  function automatic logic low_bits_full(input logic [STAGES-1:0] c,
                                         input logic [SEL_W-1:0] s);
    logic [STAGES-1:0] m;
    m = (STAGES'(1) << s) - STAGES'(1);
    return (c & m) == m;
  endfunction

  assign hit = adv & low_bits_full(cnt_q, sel);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + STAGES'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  function automatic logic at_top(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  assign ovf = step & at_top(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ovf;
      if (load)      cnt_q <= load_val;
      else if (ovf)  cnt_q <= reload_val;
      else if (step) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/evt_timer8.sv
`timescale 1ns/1ps
module evt_timer8
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_STAGES  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ext_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] ctrl,
  output logic             irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  preload_q;
  logic              lvl, rise, fall;
  logic              run, pol, active, is_event, is_pulse;
  logic              adv, hit, step, ovf, pw_end;
  logic              wr_pre, wr_ctl, load;
  logic [PSEL_W-1:0] psel;
  tmr_mode_e         mode;

  assign psel     = ctrl_q[PSEL_W-1:0];
  assign pol      = ctrl_q[POL_BIT];
  assign run      = ctrl_q[RUN_BIT];
  assign mode     = tmr_mode_e'(ctrl_q[MODE_LSB +: 2]);
  assign is_event = (mode == MD_EVENT);
  assign is_pulse = (mode == MD_PULSE);
  assign active   = pol ? ~lvl : lvl;

  assign wr_pre = wr_en & ~wr_sel;
  assign wr_ctl = wr_en & wr_sel;
  assign load   = wr_pre & ~run;

  tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign adv = tick & run & ~is_event & (~is_pulse | active);

  tmr_prescaler #(.STAGES(PRE_STAGES), .SEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(~run), .adv(adv), .sel(psel), .hit(hit)
  );

  assign step   = run & (is_event ? (pol ? fall : rise) : hit);
  assign pw_end = run & is_pulse & (pol ? rise : fall);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load),
    .load_val(wr_data), .reload_val(preload_q),
    .count(count), .ovf(ovf), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
    end else begin
      if (wr_pre) preload_q <= wr_data;
      if (wr_ctl) ctrl_q <= wr_data[CTRL_W-1:0];
      else if (pw_end) ctrl_q[RUN_BIT] <= 1'b0;
    end
  end

  assign ctrl = CNT_W'(ctrl_q);
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             tick,
  input logic [1:0]       mode_bits,
  input logic             run,
  input logic             step,
  input logic             ovf,
  input logic             pw_end,
  input logic [CNT_W-1:0] preload,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  // R3: a step below the top adds exactly one
  a_r3_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !(&count)) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

  // R4: stopped counter holds unless loaded by a preload write
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && !wr_sel)) |=> $stable(count));

  // R4: timer mode with no tick holds
  a_r4_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_bits[0] && !tick) |=> $stable(count));

  // R5: interrupt follows an overflow and the count equals the preload
  a_r5_irq_from_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ovf));
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == $past(preload)));

  // R9: end of a measured pulse clears run
  a_r9_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_end && !(wr_en && wr_sel)) |=> !run);
endmodule

bind evt_timer8 tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .tick(tick),
  .mode_bits(ctrl_q[6:5]), .run(run), .step(step), .ovf(ovf),
  .pw_end(pw_end), .preload(preload_q), .count(count), .irq(irq)
);

// File: tb/test_evt_timer8.sv
`timescale 1ns/1ps
module test_evt_timer8;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       ext_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] count, ctrl;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(HALF) clk = ~clk;

  evt_timer8 i_evt_timer8 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_in(ext_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .ctrl(ctrl), .irq(irq)
  );

  // control word: {0, mode[1:0], run, pol, psel[2:0]}
  function automatic logic [7:0] mk_ctrl(input logic [1:0] md, input logic rn,
                                         input logic pl, input logic [2:0] ps);
    return {1'b0, md, rn, pl, ps};
  endfunction

  // timer model: N ticks at divide 2^s from preload p
  function automatic logic [7:0] model_count(input int p, input int s, input int n);
    int steps = n / (1 << s);
    int span  = 256 - p;
    return 8'(p + (steps % span));
  endfunction

  function automatic int model_irqs(input int p, input int s, input int n);
    return (n / (1 << s)) / (256 - p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 irq", irq, 0);

    // R2 preload while stopped loads count
    wr(1'b0, 8'h5A);
    chk("R2 load stopped", count, 8'h5A);

    // R3 timer divide by 1
    wr(1'b1, mk_ctrl(2'b00, 1'b1, 1'b0, 3'd0));
    wait_n(4);
    chk("R3 timer run", count, 8'h5E);
    // R2 preload while running: count only takes its normal step
    wr(1'b0, 8'h10);
    chk("R2 load running", count, 8'h5F);

    // R4 tick low freezes timer
    tick = 1'b0;
    wait_n(5);
    chk("R4 tick low", count, 8'h5F);
    tick = 1'b1;
    wr(1'b1, 8'h00);
    wait_n(3);
    chk("R4 stopped", count, 8'h60);

    // R5 wrap and single-cycle irq
    wr(1'b0, 8'hFE);
    wr(1'b1, mk_ctrl(2'b00, 1'b1, 1'b0, 3'd0));
    wait_n(1);
    chk("R5 at top", count, 8'hFF);
    chk("R5 irq before", irq, 0);
    wait_n(1);
    chk("R5 reload", count, 8'hFE);
    chk("R5 irq high", irq, 1);
    wait_n(1);
    chk("R5 irq one cycle", irq, 0);
    wr(1'b1, 8'h00);

    // R6/R7 event mode, rising edges, no tick
    wr(1'b0, 8'h20);
    wr(1'b1, mk_ctrl(2'b01, 1'b1, 1'b0, 3'd0));
    tick = 1'b0;
    ext_in = 1'b1;
    wait_n(2);
    chk("R6 not yet", count, 8'h20);
    wait_n(1);
    chk("R6 third edge", count, 8'h21);
    ext_in = 1'b0;
    wait_n(4);
    chk("R7 falling ignored", count, 8'h21);
    wr(1'b1, mk_ctrl(2'b01, 1'b1, 1'b1, 3'd0));
    ext_in = 1'b1;
    wait_n(4);
    chk("R7 rising ignored", count, 8'h21);
    ext_in = 1'b0;
    wait_n(4);
    chk("R7 falling counted", count, 8'h22);
    tick = 1'b1;
    wr(1'b1, 8'h00);

    // R8/R9 pulse width, active high, divide by 2
    wr(1'b0, 8'h00);
    wr(1'b1, mk_ctrl(2'b10, 1'b1, 1'b0, 3'd1));
    ext_in = 1'b1;
    wait_n(7);
    ext_in = 1'b0;
    wait_n(5);
    chk("R8 pulse high div2", count, 3);
    chk("R9 run cleared", ctrl[4], 0);
    ext_in = 1'b1;
    wait_n(6);
    ext_in = 1'b0;
    wait_n(5);
    chk("R9 second pulse ignored", count, 3);

    // R8/R9 pulse width, active low, divide by 1
    ext_in = 1'b1;
    wait_n(4);
    wr(1'b0, 8'h40);
    wr(1'b1, mk_ctrl(2'b10, 1'b1, 1'b1, 3'd0));
    ext_in = 1'b0;
    wait_n(5);
    ext_in = 1'b1;
    wait_n(5);
    chk("R8 pulse low", count, 8'h45);
    chk("R9 run cleared low", ctrl[4], 0);

    // R3/R5 random timer runs
    for (int it = 0; it < 30; it++) begin
      int p = int'($urandom % 256);
      int s = int'($urandom % 8);
      int n = 1 + int'($urandom % 400);
      int seen = 0;
      wr(1'b1, 8'h00);
      wr(1'b0, 8'(p));
      wr(1'b1, mk_ctrl(2'b00, 1'b1, 1'b0, 3'(s)));
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        if (irq) seen++;
      end
      chk("R3 random count", count, model_count(p, s, n));
      chk("R5 random irqs", seen, model_irqs(p, s, n));
    end

    finish_run();
  end
endmodule